// File: doc/BRIEF.md
# Peripheral control register handler

This block is the control-plane register file that sits between an 8-bit microprocessor register bus and one peripheral. The bus presents an address, a write strobe, a read strobe and a byte of write data. The block answers with a registered byte of read data. Toward the peripheral it drives a reset line, a halt line, a vector of single-cycle command pulses and one masked interrupt line. It also collects peripheral event inputs and interrupt source inputs into sticky bits that software clears.

The address map is fixed:

| Region | Addresses |
|---|---|
| Readback scratch | 0x00–0x01 |
| Counter enables | 0x02–0x03 |
| Counters and thresholds | 0x04–0x2F |
| Reset/halt register | 0x30 |
| Command registers | 0x31–0x32 |
| Event latch registers | 0x33–0x37 |
| Interrupt/mask pairs | 0x38–0x47 |
| Configuration | 0x48–0x57 |

Each interrupt/mask pair takes two addresses: the mask sits on the even address and the interrupt bits sit on the odd address just above it. The counter and configuration regions are decoded but hold no storage here. Everything runs on one clock, and the block has an active-low asynchronous reset.

Top module: `pcr_ctrl`

## Requirements
- R1: After reset, periph_rst_o is 1, periph_halt_o is 0, cmd_o is all zero, irq_o is 0, and every event latch, interrupt bit and mask bit is 0.
- R2: The register at 0x30 is read/write. Bit 0 drives periph_rst_o and bit 1 drives periph_halt_o. Bits 7:2 read back as 0. A write takes effect on the outputs in the cycle after the write edge.
- R3: Writing 1 to bit j of command register 0x31+k drives cmd_o[8k+j] high for exactly the one cycle after the write edge. Bits written 0 produce no pulse.
- R4: Reading any command register returns 0x00.
- R5: An event input event_i[8k+j] that is high at a clock edge sets bit j of event latch 0x33+k. The bit then holds after the input falls.
- R6: Writing 1 to an event latch bit clears it, and writing 0 leaves it unchanged. If a set and a clear arrive in the same cycle, the bit stays set.
- R7: For pair p, irq_src_i[8p+j] sets bit j of interrupt register 0x39+2p, with the same clear and set-wins rules as R6. Mask register 0x38+2p is plain read/write.
- R8: irq_o is the OR over all pairs and bits of interrupt bit AND mask bit, where a mask bit of 1 enables the interrupt. irq_o follows register changes in the cycle after the edge.
- R9: Reads of 0x00–0x2F, 0x48–0x57 and 0x58–0xFF return 0x00. Writes to those addresses change no output and no stored register.
- R10: rdata_o is loaded at the edge where rd_i is high and is visible in the following cycle. It holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| periph_rst_o | output | 1 | Peripheral reset, high after reset |
| periph_halt_o | output | 1 | Peripheral halt |
| cmd_o | output | 16 | Command pulses, bit 8k+j for register 0x31+k bit j |
| event_i | input | 40 | Event inputs, bit 8k+j sets latch 0x33+k bit j |
| irq_src_i | input | 64 | Interrupt sources, bit 8p+j sets 0x39+2p bit j |
| irq_o | output | 1 | Masked interrupt |

## Verification
Every result here is due exactly one clock edge after its stimulus. A write or an event input sampled at edge t shows on periph_rst_o, periph_halt_o, cmd_o and irq_o in the cycle after t. Read data shows on rdata_o in the cycle after the edge that sampled rd_i. The bench drives on falling edges and samples at the next falling edge. It checks command pulses at that point and again one cycle later, which confirms the one-cycle width. The set-wins case drives an event and a clearing write into the same edge and then reads the latch back.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 8;

  localparam logic [AW-1:0] RST_ADDR = 8'h30;
  localparam logic [AW-1:0] CMD_BASE = 8'h31;
  localparam logic [AW-1:0] EVT_BASE = 8'h33;
  localparam logic [AW-1:0] IRQ_BASE = 8'h38;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_RST,
    RG_CMD,
    RG_EVT,
    RG_IRQ
  } region_e;
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode
  import pcr_pkg::*;
#(
  parameter int unsigned N_CMD = 2,
  parameter int unsigned N_EVT = 5,
  parameter int unsigned N_IRQ = 8
) (
  input  logic [AW-1:0] addr_i,
  output region_e       region_o,
  output logic [AW-1:0] idx_o,
  output logic          odd_o
);
  localparam logic [AW:0] CMD_END = (AW+1)'(CMD_BASE) + (AW+1)'(N_CMD);
  localparam logic [AW:0] EVT_END = (AW+1)'(EVT_BASE) + (AW+1)'(N_EVT);
  localparam logic [AW:0] IRQ_END = (AW+1)'(IRQ_BASE) + (AW+1)'(2 * N_IRQ);

  logic [AW:0]   a_ext;
  logic [AW-1:0] irq_off;

  assign a_ext   = {1'b0, addr_i};
  assign irq_off = addr_i - IRQ_BASE;

  always_comb begin
    region_o = RG_NONE;
    idx_o    = '0;
    odd_o    = 1'b0;
    if (addr_i == RST_ADDR) begin
      region_o = RG_RST;
    end else if (addr_i >= CMD_BASE && a_ext < CMD_END) begin
      region_o = RG_CMD;
      idx_o    = addr_i - CMD_BASE;
    end else if (addr_i >= EVT_BASE && a_ext < EVT_END) begin
      region_o = RG_EVT;
      idx_o    = addr_i - EVT_BASE;
    end else if (addr_i >= IRQ_BASE && a_ext < IRQ_END) begin
      region_o = RG_IRQ;
      idx_o    = {1'b0, irq_off[AW-1:1]};
      odd_o    = irq_off[0];
    end
  end
endmodule

// File: rtl/pcr_cmd_gen.sv
module pcr_cmd_gen
  import pcr_pkg::*;
#(
  parameter int unsigned N_REG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [AW-1:0]     idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [N_REG*DW-1:0] cmd_o
);
  logic [N_REG*DW-1:0] cmd_q;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    // pulse lasts one cycle: cleared unless rewritten
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmd_q[g*DW +: DW] <= '0;
      end else if (wr_i && idx_i == AW'(g)) begin
        cmd_q[g*DW +: DW] <= wdata_i;
      end else begin
        cmd_q[g*DW +: DW] <= '0;
      end
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/pcr_w1c_bank.sv
module pcr_w1c_bank
  import pcr_pkg::*;
#(
  parameter int unsigned N_REG = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_REG*DW-1:0] set_i,
  input  logic                clr_i,
  input  logic [AW-1:0]       idx_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [N_REG*DW-1:0] q_o
);
  logic [N_REG*DW-1:0] q;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    logic [DW-1:0] clr_mask;
    assign clr_mask = (clr_i && idx_i == AW'(g)) ? wdata_i : '0;

    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[g*DW +: DW] <= '0;
      else         q[g*DW +: DW] <= (q[g*DW +: DW] & ~clr_mask) | set_i[g*DW +: DW];
    end
  end

  assign q_o = q;
endmodule

// File: rtl/pcr_ctrl.sv
module pcr_ctrl
  import pcr_pkg::*;
#(
  parameter int unsigned N_CMD = 2,
  parameter int unsigned N_EVT = 5,
  parameter int unsigned N_IRQ = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                periph_rst_o,
  output logic                periph_halt_o,
  output logic [N_CMD*DW-1:0] cmd_o,
  input  logic [N_EVT*DW-1:0] event_i,
  input  logic [N_IRQ*DW-1:0] irq_src_i,
  output logic                irq_o
);
  region_e             region;
  logic [AW-1:0]       idx;
  logic                odd;
  logic                rst_q, halt_q;
  logic [N_EVT*DW-1:0] evt_q;
  logic [N_IRQ*DW-1:0] int_q, mask_q;
  logic [DW-1:0]       rd_val, rdata_q;

  pcr_decode #(.N_CMD(N_CMD), .N_EVT(N_EVT), .N_IRQ(N_IRQ)) i_decode (
    .addr_i  (addr_i),
    .region_o(region),
    .idx_o   (idx),
    .odd_o   (odd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b1;
      halt_q <= 1'b0;
    end else if (wr_i && region == RG_RST) begin
      rst_q  <= wdata_i[0];
      halt_q <= wdata_i[1];
    end
  end

  pcr_cmd_gen #(.N_REG(N_CMD)) i_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i && region == RG_CMD),
    .idx_i  (idx),
    .wdata_i(wdata_i),
    .cmd_o  (cmd_o)
  );

  pcr_w1c_bank #(.N_REG(N_EVT)) i_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (event_i),
    .clr_i  (wr_i && region == RG_EVT),
    .idx_i  (idx),
    .wdata_i(wdata_i),
    .q_o    (evt_q)
  );

  pcr_w1c_bank #(.N_REG(N_IRQ)) i_int (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_src_i),
    .clr_i  (wr_i && region == RG_IRQ && odd),
    .idx_i  (idx),
    .wdata_i(wdata_i),
    .q_o    (int_q)
  );

  for (genvar g = 0; g < N_IRQ; g++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[g*DW +: DW] <= '0;
      end else if (wr_i && region == RG_IRQ && !odd && idx == AW'(g)) begin
        mask_q[g*DW +: DW] <= wdata_i;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (region)
      RG_RST:  rd_val = {{(DW-2){1'b0}}, halt_q, rst_q};
      RG_EVT:  rd_val = evt_q[int'(idx)*DW +: DW];
      RG_IRQ:  rd_val = odd ? int_q[int'(idx)*DW +: DW] : mask_q[int'(idx)*DW +: DW];
      default: rd_val = '0;  // commands and unbacked regions
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o       = rdata_q;
  assign periph_rst_o  = rst_q;
  assign periph_halt_o = halt_q;
  assign irq_o         = |(int_q & mask_q);
endmodule

// File: rtl/pcr_ctrl_chk.sv
module pcr_ctrl_chk
  import pcr_pkg::*;
#(
  parameter int unsigned N_CMD = 2,
  parameter int unsigned N_EVT = 5,
  parameter int unsigned N_IRQ = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [AW-1:0]       addr_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [DW-1:0]       rdata_o,
  input logic                periph_rst_o,
  input logic                periph_halt_o,
  input logic [N_CMD*DW-1:0] cmd_o,
  input logic [N_IRQ*DW-1:0] irq_src_i,
  input logic                irq_o
);
  localparam logic [AW:0] CMD_END = (AW+1)'(CMD_BASE) + (AW+1)'(N_CMD);
  localparam logic [AW:0] IRQ_END = (AW+1)'(IRQ_BASE) + (AW+1)'(2 * N_IRQ);

  logic in_cmd, in_irq, in_unmapped;
  assign in_cmd      = addr_i >= CMD_BASE && {1'b0, addr_i} < CMD_END;
  assign in_irq      = addr_i >= IRQ_BASE && {1'b0, addr_i} < IRQ_END;
  assign in_unmapped = addr_i < RST_ADDR || {1'b0, addr_i} >= IRQ_END;

  // R2
  reset_reg_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(periph_rst_o) || !$stable(periph_halt_o)) |-> $past(wr_i && addr_i == RST_ADDR));

  // R3
  cmd_pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != '0) |-> $past(wr_i && in_cmd));

  // R4
  cmd_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && in_cmd) |-> rdata_o == '0);

  // R8
  irq_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((|irq_src_i) || (wr_i && in_irq)));

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && in_unmapped) |-> rdata_o == '0);

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> $stable(rdata_o));
endmodule

bind pcr_ctrl pcr_ctrl_chk #(.N_CMD(N_CMD), .N_EVT(N_EVT), .N_IRQ(N_IRQ)) i_pcr_ctrl_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .rdata_o      (rdata_o),
  .periph_rst_o (periph_rst_o),
  .periph_halt_o(periph_halt_o),
  .cmd_o        (cmd_o),
  .irq_src_i    (irq_src_i),
  .irq_o        (irq_o)
);

// File: tb/test_pcr_ctrl.sv
module test_pcr_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        periph_rst_o, periph_halt_o, irq_o;
  logic [15:0] cmd_o;
  logic [39:0] event_i = '0;
  logic [63:0] irq_src_i = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4ns clk_i = ~clk_i;

  pcr_ctrl i_pcr_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .periph_rst_o(periph_rst_o),
    .periph_halt_o(periph_halt_o), .cmd_o(cmd_o), .event_i(event_i),
    .irq_src_i(irq_src_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rst", periph_rst_o, 1);
    chk("R1 halt", periph_halt_o, 0);
    chk("R1 cmd", cmd_o, 0);
    chk("R1 irq", irq_o, 0);
    bus_rd(8'h30, d); chk("R1 rstreg", d, 8'h01);
    bus_rd(8'h33, d); chk("R1 evt", d, 8'h00);
    bus_rd(8'h38, d); chk("R1 mask", d, 8'h00);
  endtask

  task automatic t_reset_reg();
    logic [7:0] d;
    bus_wr(8'h30, 8'hFE);
    chk("R2 rst low", periph_rst_o, 0);
    chk("R2 halt high", periph_halt_o, 1);
    bus_rd(8'h30, d); chk("R2 readback", d, 8'h02);
    bus_wr(8'h30, 8'h01);
    chk("R2 rst high", periph_rst_o, 1);
    chk("R2 halt low", periph_halt_o, 0);
  endtask

  task automatic t_cmd();
    logic [7:0] d;
    bus_wr(8'h31, 8'h05);
    chk("R3 pulse 0x31", cmd_o, 16'h0005);
    @(negedge clk_i); chk("R3 pulse end", cmd_o, 16'h0000);
    bus_wr(8'h32, 8'h80);
    chk("R3 pulse 0x32", cmd_o, 16'h8000);
    @(negedge clk_i); chk("R3 pulse end 2", cmd_o, 16'h0000);
    bus_wr(8'h31, 8'hFF);
    bus_rd(8'h31, d); chk("R4 read 0x31", d, 8'h00);
    bus_rd(8'h32, d); chk("R4 read 0x32", d, 8'h00);
  endtask

  task automatic t_event();
    logic [7:0] d;
    @(negedge clk_i); event_i[9] = 1'b1;
    @(negedge clk_i); event_i[9] = 1'b0;
    bus_rd(8'h34, d); chk("R5 set", d, 8'h02);
    bus_rd(8'h34, d); chk("R5 held", d, 8'h02);
    bus_wr(8'h34, 8'h00);
    bus_rd(8'h34, d); chk("R6 write0 keeps", d, 8'h02);
    bus_wr(8'h34, 8'h02);
    bus_rd(8'h34, d); chk("R6 w1c", d, 8'h00);
    @(negedge clk_i);
    addr_i = 8'h34; wdata_i = 8'h02; wr_i = 1'b1; event_i[9] = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; event_i[9] = 1'b0;
    bus_rd(8'h34, d); chk("R6 set wins", d, 8'h02);
    bus_wr(8'h34, 8'hFF);
    @(negedge clk_i); event_i[39] = 1'b1;
    @(negedge clk_i); event_i[39] = 1'b0;
    bus_rd(8'h37, d); chk("R5 last latch", d, 8'h80);
    bus_rd(8'h36, d); chk("R5 neighbour", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    @(negedge clk_i); irq_src_i[10] = 1'b1;
    @(negedge clk_i); irq_src_i[10] = 1'b0;
    chk("R8 masked off", irq_o, 0);
    bus_rd(8'h3B, d); chk("R7 int bit", d, 8'h04);
    bus_wr(8'h3A, 8'h04);
    chk("R8 unmasked", irq_o, 1);
    bus_rd(8'h3A, d); chk("R7 mask rb", d, 8'h04);
    bus_wr(8'h3B, 8'h04);
    chk("R7 w1c irq", irq_o, 0);
    bus_rd(8'h3B, d); chk("R7 int cleared", d, 8'h00);
    bus_wr(8'h46, 8'h80);
    chk("R8 no src", irq_o, 0);
    @(negedge clk_i); irq_src_i[63] = 1'b1;
    @(negedge clk_i); irq_src_i[63] = 1'b0;
    chk("R8 last pair", irq_o, 1);
    bus_rd(8'h47, d); chk("R7 last int", d, 8'h80);
    bus_wr(8'h47, 8'h80);
    chk("R8 cleared", irq_o, 0);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    logic [7:0] addrs [5] = '{8'h00, 8'h2F, 8'h48, 8'h58, 8'hFF};
    bus_wr(8'h30, 8'h01);
    for (int i = 0; i < 5; i++) begin
      bus_wr(addrs[i], 8'hFF);
      chk("R9 no cmd", cmd_o, 0);
      chk("R9 rst kept", periph_rst_o, 1);
      chk("R9 halt kept", periph_halt_o, 0);
      bus_rd(addrs[i], d); chk("R9 read zero", d, 8'h00);
    end
    bus_rd(8'h30, d); chk("R9 rstreg kept", d, 8'h01);
    bus_rd(8'h38, d); chk("R9 mask kept", d, 8'h00);
  endtask

  task automatic t_rd_timing();
    logic [7:0] d;
    bus_wr(8'h30, 8'h03);
    bus_rd(8'h30, d); chk("R10 read", d, 8'h03);
    bus_wr(8'h30, 8'h00);
    @(negedge clk_i);
    chk("R10 hold", rdata_o, 8'h03);
    bus_rd(8'h30, d); chk("R10 new read", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_reset_reg();
    t_cmd();
    t_event();
    t_irq();
    t_unmapped();
    t_rd_timing();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule